// File: doc/BRIEF.md
# Three-Channel Doorbell Mailbox

This block lets a local processor and a hardwired peer exchange 32-bit doorbell words over three independent links. Every link owns two status words: one carries traffic from the peer to the local side (the local receive bank), the other carries traffic from the local side to the peer (the local transmit bank). Each bank exposes three word registers on the local register bus: a set register that ORs the written bits into status, a status register that reads the pending word, and a clear register that drops exactly the bits written as one.

The peer reaches the same two status words through a second register port whose map is the mirror image: what the local side calls its transmit bank is the peer's receive bank, and the other way round. A link's local interrupt is high while its local receive status is nonzero, so it rises when the first bits are posted. A peer interrupt follows the local transmit status in the same way. There is no completion interrupt. A sender learns that its word was consumed only by reading its transmit status until it returns zero. Channel 0 is reserved for secure traffic on the local port. A local access to channel 0 without the secure tag reads zero and changes nothing.

Both ports decode the same 0x4C-byte window. Receive banks sit at 0x00, 0x0C and 0x18 for channels 0, 1 and 2. Each transmit bank sits 0x24 above its receive bank. Inside a bank, set is at +0x0, status at +0x4 and clear at +0x8. The last word of the window, 0x48, is unused.

Top module: `doorbell_mbox`

## Requirements
- R1: After reset every status word is zero, all local and peer interrupts are low, and both read-data outputs are zero.
- R2: A write to a set register ORs the written data into that bank's status. A read of a set or clear register returns zero.
- R3: A write to a clear register clears exactly the status bits that are 1 in the written data and leaves the others unchanged.
- R4: The local interrupt of channel c (bit c of `irq_rx`) is high exactly while local receive status c is nonzero. It rises only in the cycle after bits were posted into that status.
- R5: A word that the local side sets in transmit bank c appears at the peer's receive status c, and `peer_irq[c]` goes high. After the peer writes that word to its receive clear register, the local transmit status c reads zero and `peer_irq[c]` goes low. The reverse direction, from the peer's transmit set to the local receive status, behaves the same way.
- R6: Address map on both ports: the receive bank of channel c starts at c*0x0C, the transmit bank at 0x24 + c*0x0C, with set at +0, status at +4 and clear at +8. A write to one channel leaves the other channels unchanged.
- R7: When a set and a clear reach the same status word in the same cycle, from the two ports, the new status is (old AND NOT clear) OR set. The set bits win.
- R8: An access at byte address 0x48 or above, or one whose address is not a multiple of 4, reads zero and has no effect when written.
- R9: A local-port access with `bus_secure` low to any channel 0 register reads zero and has no effect. With `bus_secure` high it acts normally. The peer port is not subject to this check.
- R10: Read data appears on the read-data output in the cycle after the request and shows the status before any write in the same cycle. Without a read request the output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Local port access request |
| bus_write | input | 1 | Local access is a write (1) or read (0) |
| bus_secure | input | 1 | Local access carries the secure tag |
| bus_addr | input | 8 | Local byte address |
| bus_wdata | input | 32 | Local write data |
| bus_rdata | output | 32 | Local read data, one cycle after the request |
| peer_valid | input | 1 | Peer port access request |
| peer_write | input | 1 | Peer access is a write (1) or read (0) |
| peer_addr | input | 8 | Peer byte address (mirrored map) |
| peer_wdata | input | 32 | Peer write data |
| peer_rdata | output | 32 | Peer read data, one cycle after the request |
| irq_rx | output | 3 | Per-channel local interrupt, high while local receive status is nonzero |
| peer_irq | output | 3 | Per-channel peer interrupt, high while local transmit status is nonzero |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a set from one port and a clear from the other port that hit the same status word. The bench drives both ports in one cycle: the local side sets part of a word while the peer clears a wider mask covering those bits. It judges the result by reading the status back and comparing it with (old AND NOT clear) OR set. The second pair is a read and a write of the same status word in one cycle. There the bench expects the value from before the write, and the new value on the following read.

// File: rtl/dbmb_pkg.sv
package dbmb_pkg;

    localparam int NUM_CHAN      = 3;
    localparam int DATA_W        = 32;
    localparam int ADDR_W        = 8;
    localparam int WORD_BYTES    = 4;
    localparam int REGS_PER_BANK = 3;
    localparam int STRIDE        = REGS_PER_BANK * WORD_BYTES;   // 0x0C
    localparam int SIDE_BYTES    = NUM_CHAN * STRIDE;            // 0x24
    localparam int USED_BYTES    = 2 * SIDE_BYTES;               // 0x48
    localparam int NUM_BANKS     = 2 * NUM_CHAN;
    localparam int CH_W          = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1;
    localparam int BI_W          = $clog2(NUM_BANKS);
    localparam int KIND_W        = 2;

    typedef enum logic [KIND_W-1:0] {
        KIND_SET  = 2'd0,
        KIND_STAT = 2'd1,
        KIND_CLR  = 2'd2,
        KIND_NONE = 2'd3
    } reg_kind_e;

    typedef struct packed {
        logic            hit;
        logic            is_tx;
        logic [CH_W-1:0] chan;
        reg_kind_e       kind;
    } dec_t;

    function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a);
        dec_t d;
        int   off;
        int   boff;
        d      = '0;
        d.kind = KIND_NONE;
        off    = int'(a);
        if (a[1:0] == 2'b00 && off < USED_BYTES) begin
            d.hit   = 1'b1;
            d.is_tx = (off >= SIDE_BYTES);
            boff    = d.is_tx ? off - SIDE_BYTES : off;
            d.chan  = CH_W'(boff / STRIDE);
            d.kind  = reg_kind_e'(KIND_W'((boff % STRIDE) / WORD_BYTES));
        end
        return d;
    endfunction

endpackage

// File: rtl/dbmb_decode.sv
module dbmb_decode
    import dbmb_pkg::*;
#(
    parameter bit SWAP_SIDES = 1'b0,
    parameter bit CHECK_SEC  = 1'b1
) (
    input  logic                 valid,
    input  logic                 write,
    input  logic                 secure,
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_BANKS-1:0] set_en,
    output logic [NUM_BANKS-1:0] clr_en,
    output logic                 rd_en,
    output logic [BI_W-1:0]      rd_bank
);
    dec_t d;
    logic allowed;
    logic tx_side;
    int   bank;

    always_comb begin
        d       = decode_addr(addr);
        allowed = valid && d.hit &&
                  !(CHECK_SEC && !secure && d.chan == '0);
        tx_side = d.is_tx ^ SWAP_SIDES;
        bank    = tx_side ? NUM_CHAN + int'(d.chan) : int'(d.chan);
        set_en  = '0;
        clr_en  = '0;
        if (allowed && write && d.kind == KIND_SET) set_en[bank] = 1'b1;
        if (allowed && write && d.kind == KIND_CLR) clr_en[bank] = 1'b1;
        rd_en   = allowed && !write && d.kind == KIND_STAT;
        rd_bank = BI_W'(bank);
    end
endmodule

// File: rtl/dbmb_bank.sv
module dbmb_bank
    import dbmb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] set_bits,
    input  logic [DATA_W-1:0] clr_bits,
    output logic [DATA_W-1:0] stat
);
    always_ff @(posedge clk) begin
        if (rst) stat <= '0;
        else     stat <= (stat & ~clr_bits) | set_bits;
    end
endmodule

// File: rtl/doorbell_mbox.sv
module doorbell_mbox
    import dbmb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic              bus_secure,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              peer_valid,
    input  logic              peer_write,
    input  logic [7:0]        peer_addr,
    input  logic [31:0]       peer_wdata,
    output logic [31:0]       peer_rdata,
    output logic [2:0]        irq_rx,
    output logic [2:0]        peer_irq
);
    logic [NUM_BANKS-1:0]             l_set, l_clr, p_set, p_clr;
    logic                             l_rd, p_rd;
    logic [BI_W-1:0]                  l_bank, p_bank;
    logic [NUM_BANKS-1:0][DATA_W-1:0] set_mask, clr_mask, stat;

    // local port: secure check on channel 0
    dbmb_decode #(.SWAP_SIDES(1'b0), .CHECK_SEC(1'b1)) i_dec_local (
        .valid(bus_valid), .write(bus_write), .secure(bus_secure),
        .addr(bus_addr), .set_en(l_set), .clr_en(l_clr),
        .rd_en(l_rd), .rd_bank(l_bank)
    );

    // peer port: mirrored banks, hardwired so no secure check
    dbmb_decode #(.SWAP_SIDES(1'b1), .CHECK_SEC(1'b0)) i_dec_peer (
        .valid(peer_valid), .write(peer_write), .secure(1'b1),
        .addr(peer_addr), .set_en(p_set), .clr_en(p_clr),
        .rd_en(p_rd), .rd_bank(p_bank)
    );

    // banks 0..N-1: local receive, N..2N-1: local transmit
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        always_comb begin
            set_mask[b] = ({DATA_W{l_set[b]}} & bus_wdata) |
                          ({DATA_W{p_set[b]}} & peer_wdata);
            clr_mask[b] = ({DATA_W{l_clr[b]}} & bus_wdata) |
                          ({DATA_W{p_clr[b]}} & peer_wdata);
        end
        dbmb_bank i_bank (
            .clk(clk), .rst(rst),
            .set_bits(set_mask[b]), .clr_bits(clr_mask[b]),
            .stat(stat[b])
        );
    end

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_irq
        assign irq_rx[c]   = |stat[c];
        assign peer_irq[c] = |stat[NUM_CHAN + c];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            peer_rdata <= '0;
        end else begin
            bus_rdata  <= l_rd ? stat[l_bank] : '0;
            peer_rdata <= p_rd ? stat[p_bank] : '0;
        end
    end
endmodule

// File: rtl/dbmb_chk.sv
module dbmb_chk
    import dbmb_pkg::*;
(
    input logic                             clk,
    input logic                             rst,
    input logic                             bus_valid,
    input logic                             bus_write,
    input logic                             bus_secure,
    input logic [ADDR_W-1:0]                bus_addr,
    input logic [DATA_W-1:0]                bus_rdata,
    input logic                             peer_valid,
    input logic [NUM_CHAN-1:0]              irq_rx,
    input logic [NUM_CHAN-1:0]              peer_irq,
    input logic [NUM_BANKS-1:0][DATA_W-1:0] set_mask,
    input logic [NUM_BANKS-1:0][DATA_W-1:0] clr_mask,
    input logic [NUM_BANKS-1:0][DATA_W-1:0] stat
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq_rx == '0 && peer_irq == '0 && bus_rdata == '0));

    // R8
    window_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $past(bus_valid && !bus_write && int'(bus_addr) >= USED_BYTES)
        |-> bus_rdata == '0);

    // R9
    nonsecure_ch0_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && !bus_secure && !peer_valid &&
         (int'(bus_addr) < STRIDE ||
          (int'(bus_addr) >= SIDE_BYTES && int'(bus_addr) < SIDE_BYTES + STRIDE)))
        |=> ($stable(stat[0]) && $stable(stat[NUM_CHAN])));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_b
        // R7
        set_wins_chk: assert property (@(posedge clk) disable iff (rst)
            (set_mask[b] != '0) |=> ((stat[b] & $past(set_mask[b])) == $past(set_mask[b])));
        // R3
        clear_bits_chk: assert property (@(posedge clk) disable iff (rst)
            (clr_mask[b] != '0) |=> ((stat[b] & $past(clr_mask[b] & ~set_mask[b])) == '0));
        // R2
        idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (set_mask[b] == '0 && clr_mask[b] == '0) |=> $stable(stat[b]));
    end

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_c
        // R4
        irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(irq_rx[c]) |-> $past(set_mask[c] != '0));
        // R5
        peer_irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(peer_irq[c]) |-> $past(set_mask[NUM_CHAN + c] != '0));
    end
endmodule

bind doorbell_mbox dbmb_chk i_dbmb_chk (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_secure(bus_secure),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .peer_valid(peer_valid),
    .irq_rx(irq_rx), .peer_irq(peer_irq),
    .set_mask(set_mask), .clr_mask(clr_mask), .stat(stat)
);

// File: tb/test_doorbell_mbox.sv
`timescale 1ns/1ps
module test_doorbell_mbox;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 0, bus_write = 0, bus_secure = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        peer_valid = 0, peer_write = 0;
    logic [7:0]  peer_addr = 0;
    logic [31:0] peer_wdata = 0;
    logic [31:0] peer_rdata;
    logic [2:0]  irq_rx, peer_irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    doorbell_mbox i_doorbell_mbox (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_secure(bus_secure),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .peer_valid(peer_valid), .peer_write(peer_write), .peer_addr(peer_addr),
        .peer_wdata(peer_wdata), .peer_rdata(peer_rdata),
        .irq_rx(irq_rx), .peer_irq(peer_irq)
    );

    function automatic logic [7:0] rxa(int c, int k);
        return 8'(c * 12 + k * 4);
    endfunction
    function automatic logic [7:0] txa(int c, int k);
        return 8'(36 + c * 12 + k * 4);
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic lwr(logic [7:0] a, logic [31:0] d, bit sec);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d; bus_secure = sec;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic lrd(logic [7:0] a, bit sec, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = a; bus_secure = sec;
        @(negedge clk);
        bus_valid = 0;
        d = bus_rdata;
    endtask

    task automatic pwr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        peer_valid = 1; peer_write = 1; peer_addr = a; peer_wdata = d;
        @(negedge clk);
        peer_valid = 0; peer_write = 0;
    endtask

    task automatic prd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        peer_valid = 1; peer_write = 0; peer_addr = a;
        @(negedge clk);
        peer_valid = 0;
        d = peer_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 irq_rx", {29'd0, irq_rx}, 0);
        chk("R1 peer_irq", {29'd0, peer_irq}, 0);
        for (int c = 0; c < 3; c++) begin
            lrd(rxa(c, 1), 1, v); chk("R1 rx stat", v, 0);
            lrd(txa(c, 1), 1, v); chk("R1 tx stat", v, 0);
        end
    endtask

    task automatic t_set_or();
        logic [31:0] v;
        pwr(txa(1, 0), 32'h5);
        chk("R4 irq rises", {29'd0, irq_rx}, 32'h2);
        pwr(txa(1, 0), 32'hA0);
        lrd(rxa(1, 1), 0, v); chk("R2 OR into status", v, 32'hA5);
        lrd(rxa(1, 0), 0, v); chk("R2 set reads zero", v, 0);
        lrd(rxa(1, 2), 0, v); chk("R2 clr reads zero", v, 0);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        lwr(rxa(1, 2), 32'h05, 0);
        lrd(rxa(1, 1), 0, v); chk("R3 partial clear", v, 32'hA0);
        chk("R4 irq stays", {29'd0, irq_rx}, 32'h2);
        lwr(rxa(1, 2), 32'hA0, 0);
        lrd(rxa(1, 1), 0, v); chk("R3 full clear", v, 0);
        chk("R4 irq falls", {29'd0, irq_rx}, 0);
    endtask

    task automatic t_tx_poll();
        logic [31:0] v;
        lwr(txa(2, 0), 32'h1234, 1);
        chk("R5 peer_irq high", {29'd0, peer_irq}, 32'h4);
        lrd(txa(2, 1), 1, v); chk("R5 tx stat pending", v, 32'h1234);
        prd(rxa(2, 1), v);    chk("R5 peer rx stat", v, 32'h1234);
        pwr(rxa(2, 2), v);
        lrd(txa(2, 1), 1, v); chk("R5 tx poll zero", v, 0);
        chk("R5 peer_irq low", {29'd0, peer_irq}, 0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        for (int c = 0; c < 3; c++) lwr(txa(c, 0), 32'h100 + c, 1);
        for (int c = 0; c < 3; c++) begin
            prd(rxa(c, 1), v); chk("R6 channel map", v, 32'h100 + c);
        end
        chk("R6 peer_irq all", {29'd0, peer_irq}, 32'h7);
        pwr(rxa(1, 2), 32'hFFFF_FFFF);
        lrd(txa(0, 1), 1, v); chk("R6 ch0 untouched", v, 32'h100);
        lrd(txa(2, 1), 1, v); chk("R6 ch2 untouched", v, 32'h102);
        chk("R6 rx untouched", {29'd0, irq_rx}, 0);
        pwr(rxa(0, 2), 32'hFFFF_FFFF);
        pwr(rxa(2, 2), 32'hFFFF_FFFF);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        lwr(txa(1, 0), 32'hF0, 0);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_secure = 0; bus_addr = txa(1, 0); bus_wdata = 32'h0F;
        peer_valid = 1; peer_write = 1; peer_addr = rxa(1, 2); peer_wdata = 32'hFF;
        @(negedge clk);
        bus_valid = 0; bus_write = 0; peer_valid = 0; peer_write = 0;
        lrd(txa(1, 1), 0, v); chk("R7 set wins", v, 32'h0F);
        pwr(rxa(1, 2), 32'h0F);
    endtask

    task automatic t_window();
        logic [31:0] v;
        lwr(8'h48, 32'hFFFF_FFFF, 1);
        lwr(8'h4C, 32'hFFFF_FFFF, 1);
        lwr(8'h80, 32'hFFFF_FFFF, 1);
        lwr(8'h31, 32'hFFFF_FFFF, 1);
        pwr(8'h25, 32'hFFFF_FFFF);
        chk("R8 no irq from stray writes", {26'd0, irq_rx, peer_irq}, 0);
        for (int c = 0; c < 3; c++) begin
            lrd(txa(c, 1), 1, v); chk("R8 tx unchanged", v, 0);
        end
        lwr(txa(2, 0), 32'h55, 1);
        lrd(8'h41, 1, v); chk("R8 unaligned read", v, 0);
        lrd(8'h40, 1, v); chk("R8 aligned read", v, 32'h55);
        lrd(8'h48, 1, v); chk("R8 unused word", v, 0);
        lrd(8'h80, 1, v); chk("R8 beyond window", v, 0);
        lwr(txa(2, 2), 32'h55, 1);
    endtask

    task automatic t_secure();
        logic [31:0] v;
        pwr(txa(0, 0), 32'h77);
        chk("R9 peer ch0 posts", {29'd0, irq_rx}, 32'h1);
        lrd(rxa(0, 1), 0, v); chk("R9 nonsecure read zero", v, 0);
        lwr(rxa(0, 2), 32'h77, 0);
        lrd(rxa(0, 1), 1, v); chk("R9 nonsecure clear ignored", v, 32'h77);
        lwr(txa(0, 0), 32'h9, 0);
        chk("R9 nonsecure set ignored", {29'd0, peer_irq}, 0);
        lwr(rxa(0, 2), 32'h77, 1);
        lrd(rxa(0, 1), 1, v); chk("R9 secure clear", v, 0);
    endtask

    task automatic t_rd_timing();
        logic [31:0] v;
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_secure = 1; bus_addr = txa(1, 0); bus_wdata = 32'h3;
        peer_valid = 1; peer_write = 0; peer_addr = rxa(1, 1);
        @(negedge clk);
        bus_valid = 0; bus_write = 0; peer_valid = 0;
        chk("R10 old value same cycle", peer_rdata, 0);
        @(negedge clk);
        chk("R10 idle output zero", peer_rdata, 0);
        prd(rxa(1, 1), v); chk("R10 new value next read", v, 32'h3);
        pwr(rxa(1, 2), 32'h3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_set_or();
        t_clear();
        t_tx_poll();
        t_map();
        t_collision();
        t_window();
        t_secure();
        t_rd_timing();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule